// File: doc/BRIEF.md
# Sub-Area Cross-Correlation Peak Engine

This block measures how far a particle pattern has moved between two image snapshots. For each interrogation window it receives two sets of pixels. The first is the full window taken from the later frame. The second is a smaller sub-area taken from the earlier frame. Both sets are stored in on-chip RAM. The block then slides the sub-area over every position where it fits completely inside the window. At each position it forms the sum of pixel products, which is the correlation score. Each score is written to a result RAM, and the block keeps track of the position with the highest score. When the search is over, the winning integer displacement and its score appear on the outputs. The same values are also stored in a peak memory at the slot the caller chose for this window.

The block is controlled by a state machine with seven states:
- `ST_IDLE` waits for `start`. A start moves it to `ST_LD_WIN`.
- `ST_LD_WIN` receives the window pixels. After the last one it moves to `ST_LD_SUB`.
- `ST_LD_SUB` receives the sub-area pixels. After the last one it moves to `ST_MAC`.
- `ST_MAC` issues one pair of RAM reads per cycle for the current shift. After the last pair it moves to `ST_DRAIN`.
- `ST_DRAIN` adds the last product, which arrives one cycle late. It then moves to `ST_STORE`.
- `ST_STORE` writes the score and updates the running best. It returns to `ST_MAC` if more shifts remain, and goes to `ST_PEAK` after the final shift.
- `ST_PEAK` writes the peak entry and raises `done`. It then returns to `ST_IDLE`.

An address generator holds the sub-area coordinate and the current shift. From these it produces both RAM read addresses. The window size, sub-area size, pixel width and number of peak slots are all parameters.

Top module: `xcorr_peak_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and `peak_s`, `peak_t` and `peak_score` are zero.
- R2: A `start` seen in `ST_IDLE` is accepted, and `busy` is high on the next cycle. The block then takes WIN*WIN window pixels followed by SUB*SUB sub-area pixels, each set in raster order (row by row, column fastest). A pixel is taken only on a cycle where `pix_valid` is high. Gaps in `pix_valid` do not change the result, and pixels offered while idle are ignored.
- R3: The score for shift (s,t) equals the sum over all sub-area points (x,y) of sub(x,y)·win(x+s, y+t). Here s is a column offset and t is a row offset, each ranging over 0..WIN−SUB. The sum is exact even when every pixel holds its maximum value.
- R4: After a run, the score for shift (s,t) can be read on `sc_rd_data` one cycle after `sc_rd_addr` is set to t·(WIN−SUB+1)+s.
- R5: The reported peak is the largest score. When several shifts share that score, the one with the smallest index t·(WIN−SUB+1)+s is chosen.
- R6: `done` is high for exactly one cycle per run, and `busy` is low on the following cycle.
- R7: While the block is idle, `peak_s`, `peak_t` and `peak_score` hold their values until a new start is accepted.
- R8: At the end of a run, the peak memory slot given by `win_sel` at start time receives {score, t, s}. The score sits in the upper ACC_W bits, t in the next SH_W bits and s in the lowest SH_W bits. The entry is read on `pk_rd_data` one cycle after `pk_rd_addr` is set. Other slots keep their contents.
- R9: A `start` seen while `busy` is high is ignored. It neither restarts the run nor changes the slot that receives the peak.
- R10: Whenever `done` is high, `peak_s` and `peak_t` are both less than WIN−SUB+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| win_sel | input | IDX_W | Peak memory slot for this run, sampled with start |
| pix_valid | input | 1 | Qualifies `pix_data` during loading |
| pix_data | input | PIX_W | Unsigned pixel value |
| sc_rd_addr | input | SHI_W | Result RAM read address (shift index) |
| sc_rd_data | output | ACC_W | Result RAM read data, one cycle latency |
| pk_rd_addr | input | IDX_W | Peak memory read address |
| pk_rd_data | output | ACC_W+2*SH_W | Peak memory read data {score,t,s}, one cycle latency |
| busy | output | 1 | High from the accepted start through the peak write |
| done | output | 1 | One-cycle pulse when the peak is final |
| peak_s | output | SH_W | Column offset of the peak |
| peak_t | output | SH_W | Row offset of the peak |
| peak_score | output | ACC_W | Score of the peak |

## Verification
The assertions assume that `start` arrives as a single-cycle pulse and that the block is only ever configured with WIN larger than SUB. They also assume that `pix_data` is treated as unsigned, which makes the accumulator grow monotonically within a shift. The stimulus raises `start` for one cycle only. While loading, it offers exactly the number of pixels the block expects, so no pixel of one run spills into the next. The pixel values are limited to the declared pixel width, and the all-maximum case is included to reach the top of the accumulator's range.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_WIN,
        ST_LD_SUB,
        ST_MAC,
        ST_DRAIN,
        ST_STORE,
        ST_PEAK
    } xc_state_e;

endpackage

// File: rtl/xc_ram.sv
module xc_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/xc_addr_gen.sv
module xc_addr_gen #(
    parameter int WIN   = 40,
    parameter int SUB   = 32,
    localparam int NS    = WIN - SUB + 1,
    localparam int NSH   = NS * NS,
    localparam int WA_W  = $clog2(WIN * WIN),
    localparam int SA_W  = $clog2(SUB * SUB),
    localparam int XY_W  = $clog2(SUB),
    localparam int SH_W  = $clog2(NS + 1),
    localparam int SHI_W = $clog2(NSH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_pix,
    input  logic             step_shift,
    output logic [WA_W-1:0]  win_addr,
    output logic [SA_W-1:0]  sub_addr,
    output logic [SHI_W-1:0] sh_idx,
    output logic [SH_W-1:0]  sh_s,
    output logic [SH_W-1:0]  sh_t,
    output logic             last_pix,
    output logic             last_shift
);

    logic [XY_W-1:0]  x_q, y_q;
    logic [SH_W-1:0]  s_q, t_q;
    logic [SHI_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            s_q   <= '0;
            t_q   <= '0;
            idx_q <= '0;
        end else if (clr) begin
            x_q   <= '0;
            y_q   <= '0;
            s_q   <= '0;
            t_q   <= '0;
            idx_q <= '0;
        end else begin
            if (step_pix) begin
                if (x_q == XY_W'(SUB - 1)) begin
                    x_q <= '0;
                    y_q <= (y_q == XY_W'(SUB - 1)) ? '0 : y_q + 1'b1;
                end else begin
                    x_q <= x_q + 1'b1;
                end
            end
            if (step_shift) begin
                idx_q <= idx_q + 1'b1;
                if (s_q == SH_W'(NS - 1)) begin
                    s_q <= '0;
                    t_q <= t_q + 1'b1;
                end else begin
                    s_q <= s_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        win_addr   = (WA_W'(y_q) + WA_W'(t_q)) * WA_W'(WIN) + WA_W'(x_q) + WA_W'(s_q);
        sub_addr   = SA_W'(y_q) * SA_W'(SUB) + SA_W'(x_q);
        sh_idx     = idx_q;
        sh_s       = s_q;
        sh_t       = t_q;
        last_pix   = (x_q == XY_W'(SUB - 1)) && (y_q == XY_W'(SUB - 1));
        last_shift = (s_q == SH_W'(NS - 1)) && (t_q == SH_W'(NS - 1));
    end

endmodule

// File: rtl/xcorr_peak_engine.sv
module xcorr_peak_engine
    import xcorr_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int WIN   = 40,
    parameter int SUB   = 32,
    parameter int NWIN  = 16,
    localparam int NPW   = WIN * WIN,
    localparam int NPS   = SUB * SUB,
    localparam int NS    = WIN - SUB + 1,
    localparam int NSH   = NS * NS,
    localparam int WA_W  = $clog2(NPW),
    localparam int SA_W  = $clog2(NPS),
    localparam int SH_W  = $clog2(NS + 1),
    localparam int SHI_W = $clog2(NSH),
    localparam int IDX_W = $clog2(NWIN),
    localparam int ACC_W = 2 * PIX_W + $clog2(NPS),
    localparam int PK_W  = ACC_W + 2 * SH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] win_sel,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [SHI_W-1:0] sc_rd_addr,
    output logic [ACC_W-1:0] sc_rd_data,
    input  logic [IDX_W-1:0] pk_rd_addr,
    output logic [PK_W-1:0]  pk_rd_data,
    output logic             busy,
    output logic             done,
    output logic [SH_W-1:0]  peak_s,
    output logic [SH_W-1:0]  peak_t,
    output logic [ACC_W-1:0] peak_score
);

    xc_state_e state_q, state_d;

    logic [WA_W-1:0]  ld_cnt_q;
    logic [IDX_W-1:0] slot_q;
    logic [ACC_W-1:0] acc_q;
    logic             rd_vld_q;
    logic [SH_W-1:0]  best_s_q, best_t_q;
    logic [ACC_W-1:0] best_sc_q;

    logic             win_we, sub_we, res_we, pk_we;
    logic             gen_clr, gen_step_pix, gen_step_shift;
    logic [WA_W-1:0]  win_raddr;
    logic [SA_W-1:0]  sub_raddr;
    logic [SHI_W-1:0] sh_idx;
    logic [SH_W-1:0]  sh_s, sh_t;
    logic             last_pix, last_shift;
    logic [PIX_W-1:0] win_q, sub_q;
    logic [2*PIX_W-1:0] prod;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LD_WIN;
            ST_LD_WIN: if (pix_valid && ld_cnt_q == WA_W'(NPW - 1)) state_d = ST_LD_SUB;
            ST_LD_SUB: if (pix_valid && ld_cnt_q == WA_W'(NPS - 1)) state_d = ST_MAC;
            ST_MAC:    if (last_pix) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_STORE;
            ST_STORE:  state_d = last_shift ? ST_PEAK : ST_MAC;
            ST_PEAK:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output and control decode
    always_comb begin
        busy           = (state_q != ST_IDLE);
        done           = (state_q == ST_PEAK);
        win_we         = (state_q == ST_LD_WIN) && pix_valid;
        sub_we         = (state_q == ST_LD_SUB) && pix_valid;
        res_we         = (state_q == ST_STORE);
        pk_we          = (state_q == ST_PEAK);
        gen_clr        = (state_q == ST_IDLE);
        gen_step_pix   = (state_q == ST_MAC);
        gen_step_shift = (state_q == ST_STORE);
        peak_s         = best_s_q;
        peak_t         = best_t_q;
        peak_score     = best_sc_q;
        prod           = win_q * sub_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_cnt_q  <= '0;
            slot_q    <= '0;
            acc_q     <= '0;
            rd_vld_q  <= 1'b0;
            best_s_q  <= '0;
            best_t_q  <= '0;
            best_sc_q <= '0;
        end else begin
            rd_vld_q <= (state_q == ST_MAC);
            if (state_q == ST_IDLE) begin
                ld_cnt_q <= '0;
                if (start) slot_q <= win_sel;
            end else if (win_we) begin
                ld_cnt_q <= (ld_cnt_q == WA_W'(NPW - 1)) ? '0 : ld_cnt_q + 1'b1;
            end else if (sub_we) begin
                ld_cnt_q <= ld_cnt_q + 1'b1;
            end
            if (state_q == ST_STORE || state_q == ST_IDLE) begin
                acc_q <= '0;
            end else if (rd_vld_q) begin
                acc_q <= acc_q + ACC_W'(prod);
            end
            if (state_q == ST_STORE && (sh_idx == '0 || acc_q > best_sc_q)) begin
                best_sc_q <= acc_q;
                best_s_q  <= sh_s;
                best_t_q  <= sh_t;
            end
        end
    end

    xc_addr_gen #(.WIN(WIN), .SUB(SUB)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (gen_clr),
        .step_pix   (gen_step_pix),
        .step_shift (gen_step_shift),
        .win_addr   (win_raddr),
        .sub_addr   (sub_raddr),
        .sh_idx     (sh_idx),
        .sh_s       (sh_s),
        .sh_t       (sh_t),
        .last_pix   (last_pix),
        .last_shift (last_shift)
    );

    xc_ram #(.DW(PIX_W), .DEPTH(NPW)) u_win_ram (
        .clk   (clk),
        .we    (win_we),
        .waddr (ld_cnt_q),
        .wdata (pix_data),
        .raddr (win_raddr),
        .rdata (win_q)
    );

    xc_ram #(.DW(PIX_W), .DEPTH(NPS)) u_sub_ram (
        .clk   (clk),
        .we    (sub_we),
        .waddr (ld_cnt_q[SA_W-1:0]),
        .wdata (pix_data),
        .raddr (sub_raddr),
        .rdata (sub_q)
    );

    xc_ram #(.DW(ACC_W), .DEPTH(NSH)) u_res_ram (
        .clk   (clk),
        .we    (res_we),
        .waddr (sh_idx),
        .wdata (acc_q),
        .raddr (sc_rd_addr),
        .rdata (sc_rd_data)
    );

    xc_ram #(.DW(PK_W), .DEPTH(NWIN)) u_pk_ram (
        .clk   (clk),
        .we    (pk_we),
        .waddr (slot_q),
        .wdata ({best_sc_q, best_t_q, best_s_q}),
        .raddr (pk_rd_addr),
        .rdata (pk_rd_data)
    );

endmodule

// File: rtl/xcorr_peak_engine_chk.sv
module xcorr_peak_engine_chk #(
    parameter int ACC_W = 8,
    parameter int SH_W  = 2,
    parameter int NS    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [SH_W-1:0]  peak_s,
    input logic [SH_W-1:0]  peak_t,
    input logic [ACC_W-1:0] peak_score,
    input logic             acc_en,
    input logic [ACC_W-1:0] acc
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> acc >= $past(acc));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R7
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(peak_score) && $stable(peak_s) && $stable(peak_t));

    // R10
    peak_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (peak_s < SH_W'(NS)) && (peak_t < SH_W'(NS)));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind xcorr_peak_engine xcorr_peak_engine_chk #(
    .ACC_W (ACC_W),
    .SH_W  (SH_W),
    .NS    (NS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .peak_s     (peak_s),
    .peak_t     (peak_t),
    .peak_score (peak_score),
    .acc_en     (rd_vld_q),
    .acc        (acc_q)
);

// File: tb/xcorr_peak_engine_bench.sv
`timescale 1ns/1ps
module xcorr_peak_engine_bench;

    localparam int PW    = 4;
    localparam int WN    = 6;
    localparam int SB    = 4;
    localparam int NW    = 4;
    localparam int NS    = WN - SB + 1;
    localparam int NSH   = NS * NS;
    localparam int NPW   = WN * WN;
    localparam int NPS   = SB * SB;
    localparam int SH_W  = 2;
    localparam int SHI_W = 4;
    localparam int IDX_W = 2;
    localparam int ACC_W = 12;
    localparam int PK_W  = 16;

    // stimulus table: {mode[7:0], slot[3:0], seed[3:0]}
    localparam logic [15:0] VEC [6] = '{
        16'h0001, 16'h0115, 16'h0220, 16'h0330, 16'h0410, 16'h0127
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [IDX_W-1:0] win_sel;
    logic             pix_valid;
    logic [PW-1:0]    pix_data;
    logic [SHI_W-1:0] sc_rd_addr;
    logic [ACC_W-1:0] sc_rd_data;
    logic [IDX_W-1:0] pk_rd_addr;
    logic [PK_W-1:0]  pk_rd_data;
    logic             busy, done;
    logic [SH_W-1:0]  peak_s, peak_t;
    logic [ACC_W-1:0] peak_score;

    int n_chk = 0;
    int n_err = 0;
    int wpx [NPW];
    int spx [NPS];
    int esc [NSH];
    int eb_s, eb_t, eb_sc;

    always #2.5 clk = ~clk;

    xcorr_peak_engine #(.PIX_W(PW), .WIN(WN), .SUB(SB), .NWIN(NW)) u_xcorr_peak_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .win_sel    (win_sel),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .sc_rd_addr (sc_rd_addr),
        .sc_rd_data (sc_rd_data),
        .pk_rd_addr (pk_rd_addr),
        .pk_rd_data (pk_rd_data),
        .busy       (busy),
        .done       (done),
        .peak_s     (peak_s),
        .peak_t     (peak_t),
        .peak_score (peak_score)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int gen_sub(int mode, int seed, int j);
        case (mode)
            0: return (j * 5 + seed * 11 + 1) % 16;
            1: return (j * 3 + seed) % 16;
            3: return 15;
            4: return (j == 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int gen_win(int mode, int seed, int i);
        int x = i % WN;
        int y = i / WN;
        int ps = seed % NS;
        int pt = (seed / NS) % NS;
        case (mode)
            0: return (i * 7 + seed * 3 + i / 4) % 16;
            1: begin
                if (x >= ps && x < ps + SB && y >= pt && y < pt + SB)
                    return gen_sub(1, seed, (y - pt) * SB + (x - ps));
                return 0;
            end
            3: return 15;
            4: return (i == 2 || i == 6) ? 9 : i % 5;
            default: return 0;
        endcase
    endfunction

    task automatic build_model(input int mode, input int seed);
        for (int i = 0; i < NPW; i++) wpx[i] = gen_win(mode, seed, i);
        for (int j = 0; j < NPS; j++) spx[j] = gen_sub(mode, seed, j);
        for (int t = 0; t < NS; t++) begin
            for (int s = 0; s < NS; s++) begin
                int acc = 0;
                for (int y = 0; y < SB; y++)
                    for (int x = 0; x < SB; x++)
                        acc += spx[y * SB + x] * wpx[(y + t) * WN + x + s];
                esc[t * NS + s] = acc;
                // strict greater-than, first in raster order wins ties
                if ((t == 0 && s == 0) || acc > eb_sc) begin
                    eb_sc = acc;
                    eb_s  = s;
                    eb_t  = t;
                end
            end
        end
    endtask

    task automatic read_pk(input int slot, output longint val);
        pk_rd_addr = IDX_W'(slot);
        @(negedge clk);
        val = pk_rd_data;
    endtask

    task automatic run_win(input int mode, input int seed, input int slot,
                           input bit gaps, input int stray_at);
        int n = 0;
        longint v;
        build_model(mode, seed);
        start   = 1'b1;
        win_sel = IDX_W'(slot);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < NPW + NPS; k++) begin
            if (gaps && (k % 3 == 1)) begin
                pix_valid = 1'b0;
                pix_data  = 4'hF;
                @(negedge clk);
            end
            pix_valid = 1'b1;
            pix_data  = PW'((k < NPW) ? wpx[k] : spx[k - NPW]);
            if (k == stray_at) begin
                start   = 1'b1;
                win_sel = IDX_W'(slot ^ 3);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        pix_valid = 1'b0;
        start     = 1'b0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R6 done seen", done, 1);
        check("R5 peak_s", peak_s, eb_s);
        check("R5 peak_t", peak_t, eb_t);
        check("R3 peak_score", peak_score, eb_sc);
        @(negedge clk);
        check("R6 done low after pulse", done, 0);
        check("R6 busy low after done", busy, 0);
        for (int sh = 0; sh < NSH; sh++) begin
            sc_rd_addr = SHI_W'(sh);
            @(negedge clk);
            check("R4 stored score", sc_rd_data, esc[sh]);
        end
        read_pk(slot, v);
        check("R8 peak entry", v, (longint'(eb_sc) << 4) | (eb_t << 2) | eb_s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        longint v;
        int hs, ht, hsc;
        rst_n      = 1'b0;
        start      = 1'b0;
        win_sel    = '0;
        pix_valid  = 1'b0;
        pix_data   = '0;
        sc_rd_addr = '0;
        pk_rd_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 peak_s", peak_s, 0);
        check("R1 peak_t", peak_t, 0);
        check("R1 peak_score", peak_score, 0);

        // table walk: random, planted, all-zero tie, all-max (R3 width), split tie (R5)
        for (int v_i = 0; v_i < 6; v_i++) begin
            run_win(int'(VEC[v_i][15:8]), int'(VEC[v_i][3:0]), int'(VEC[v_i][7:4]), 1'b0, -1);
        end

        // R7: idle with pixel traffic, peak outputs stay
        hs = peak_s; ht = peak_t; hsc = peak_score;
        for (int k = 0; k < 10; k++) begin
            pix_valid = k[0];
            pix_data  = PW'(k);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        check("R7 peak_s held", peak_s, hs);
        check("R7 peak_t held", peak_t, ht);
        check("R7 peak_score held", peak_score, hsc);
        check("R2 idle pixels ignored busy", busy, 0);

        // R2 gaps in pix_valid, R9 stray start during load aimed at slot 3
        run_win(0, 3, 0, 1'b1, 20);
        read_pk(3, v);
        check("R9 slot 3 untouched by stray start", v, longint'(3600) << 4);
        read_pk(1, v);
        check("R8 slot 1 kept split-tie entry", v, (longint'(9) << 4) | 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule